// File: doc/BRIEF.md
# Cascaded Display-Slice Address Gate

Up to four segment-driver slices can share one serial bus. Each slice has a 2-bit strap address from pins and a device-address register that a bus command loads. This block compares the two. It lets a display byte into the local RAM only when they agree. It still advances the RAM pointer on every byte, so all slices keep the same pointer whichever one is addressed. It drives the serial readout line for status and temperature reads only when the slice is selected, and leaves the line in high-impedance otherwise.

The block also decides the role of the slice on the shared clock line. The slice strapped to address 00, with its oscillator selected as internal and clock output enabled, drives its oscillator onto the line, and only while the display is enabled. A slice whose oscillator-select pin is high takes its core clock from the shared line.

A two-state bus tracker governs when the strap pins are sampled. In state `IDLE`, entered from reset and whenever `bus_active` is low, the strap register follows the pins on every clock edge. In state `BUSY`, entered from `IDLE` when `bus_active` goes high, the strap register holds its value. The tracker returns to `IDLE` when `bus_active` falls.

Top module: `slice_addr_gate`

## Requirements
- R1: While `rst_n` is low and in the cycle after it, `ram_we`, `sdo_oe` and `clk_oe` are 0, `ptr` is 0, and the device-address register is 00.
- R2: When `data_valid` is high at a clock edge and the device-address register equals the sampled strap address, `ram_we` is 1 for the next cycle, with `ram_addr` holding the pointer value before that edge and `ram_wdata` holding `data_in`.
- R3: When `data_valid` is high at a clock edge and the two addresses differ, `ram_we` stays 0, but `ptr` still advances by one.
- R4: `ptr` steps from RAM_DEPTH-1 to 0. `ptr_load` at an edge sets `ptr` to `ptr_val`, and `ptr_load` takes priority over `data_valid`.
- R5: When `rd_req` is high at an edge and the addresses match, `sdo_oe` is 1 in the next cycle, and `sdo_bit` carries the `rd_bit` value that was sampled at that edge.
- R6: When the addresses differ, `sdo_oe` is 0 in the next cycle, which means the line is left in high-impedance. `sdo_bit` is also 0 in that case.
- R7: The strap pins are taken in only at edges where the tracker is in `IDLE`. A change on the pins while the tracker is in `BUSY` has no effect on selection until the tracker is back in `IDLE`.
- R8: `clk_oe` is 1 in the cycle after an edge exactly when all of these held at that edge: the sampled strap is 00, `osc_ext` is 0, `clk_out_en` is 1, and `disp_en` is 1.
- R9: `clk_out` equals `osc_clk` while `clk_oe` is 1 and is 0 otherwise. A low `disp_en` therefore stops the clock output one cycle later.
- R10: `core_clk` is `clk_pin_in` when `osc_ext` is 1 and `osc_clk` when it is 0, with no register in the path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strap_addr | input | 2 | Hardware address pins |
| bus_active | input | 1 | A bus transaction is in progress |
| addr_load | input | 1 | Load the device-address register |
| addr_val | input | 2 | New device-address register value |
| data_valid | input | 1 | A display byte is present |
| data_in | input | DATA_W | Display byte |
| ptr_load | input | 1 | Load the data pointer |
| ptr_val | input | PTR_W | New pointer value |
| rd_req | input | 1 | Readout bit request |
| rd_bit | input | 1 | Status or temperature bit to send |
| osc_ext | input | 1 | Oscillator select: 1 takes the clock from the shared line |
| clk_out_en | input | 1 | Clock-output-enable bit |
| disp_en | input | 1 | Display enabled |
| osc_clk | input | 1 | Internal oscillator |
| clk_pin_in | input | 1 | Value seen on the shared clock line |
| ram_we | output | 1 | RAM write strobe |
| ram_addr | output | PTR_W | RAM write address |
| ram_wdata | output | DATA_W | RAM write data |
| ptr | output | PTR_W | Current data pointer |
| sdo_bit | output | 1 | Serial readout value |
| sdo_oe | output | 1 | Readout driver enable; 0 means high-impedance |
| clk_out | output | 1 | Value to drive onto the shared clock line |
| clk_oe | output | 1 | Shared clock line driver enable |
| core_clk | output | 1 | Clock selected for the core |

## Verification
The write strobe, the write address and data, the pointer, the readout enable and bit, and `clk_oe` each pass through one register. They are all due in the first cycle after the edge that samples their inputs. `clk_out` and `core_clk` follow their inputs within the same cycle. A new strap value takes part in selection only after one full edge spent in `IDLE`. The bench changes inputs 1 ns after a rising edge and reads outputs 1 ns after the next rising edge. For the combinational paths it reads after a short delay with no edge in between. Every expected value comes from the requirement timing above.

// File: rtl/slice_gate_pkg.sv
package slice_gate_pkg;
    typedef enum logic [0:0] {
        IDLE = 1'b0,
        BUSY = 1'b1
    } bus_state_t;

    localparam int ADDR_W      = 2;
    localparam logic [ADDR_W-1:0] MASTER_ADDR = '0;
endpackage

// File: rtl/addr_select.sv
module addr_select
    import slice_gate_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] strap_addr,
    input  logic              bus_active,
    input  logic              addr_load,
    input  logic [ADDR_W-1:0] addr_val,
    output logic [ADDR_W-1:0] strap_q,
    output logic              hit
);
    bus_state_t        state_q, state_d;
    logic [ADDR_W-1:0] dev_addr_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            IDLE: if (bus_active)  state_d = BUSY;
            BUSY: if (!bus_active) state_d = IDLE;
            default: state_d = IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            strap_q    <= '0;
            dev_addr_q <= '0;
        end else begin
            if (state_q == IDLE) strap_q <= strap_addr;
            if (addr_load)       dev_addr_q <= addr_val;
        end
    end

    assign hit = (dev_addr_q == strap_q);

    // R7: strap register frozen during a transaction
    p_strap_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == BUSY) |=> $stable(strap_q));

    p_state_enter_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == IDLE && bus_active) |=> (state_q == BUSY));
endmodule

// File: rtl/ptr_gate.sv
module ptr_gate #(
    parameter int RAM_DEPTH = 102,
    parameter int DATA_W    = 8,
    localparam int PTR_W    = $clog2(RAM_DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hit,
    input  logic              data_valid,
    input  logic [DATA_W-1:0] data_in,
    input  logic              ptr_load,
    input  logic [PTR_W-1:0]  ptr_val,
    output logic              ram_we,
    output logic [PTR_W-1:0]  ram_addr,
    output logic [DATA_W-1:0] ram_wdata,
    output logic [PTR_W-1:0]  ptr
);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(RAM_DEPTH - 1);

    logic [PTR_W-1:0] ptr_next;

    always_comb begin
        if (ptr_load)        ptr_next = ptr_val;
        else if (data_valid) ptr_next = (ptr == LAST) ? '0 : ptr + 1'b1;
        else                 ptr_next = ptr;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr       <= '0;
            ram_we    <= 1'b0;
            ram_addr  <= '0;
            ram_wdata <= '0;
        end else begin
            ptr    <= ptr_next;
            ram_we <= data_valid && !ptr_load && hit;
            if (data_valid) begin
                ram_addr  <= ptr;
                ram_wdata <= data_in;
            end
        end
    end

    // R3: pointer advances on every byte, selected or not
    p_ptr_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (data_valid && !ptr_load && ptr != LAST) |=> (ptr == $past(ptr) + 1'b1));

    // R4: wrap at the last RAM address
    p_ptr_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (data_valid && !ptr_load && ptr == LAST) |=> (ptr == '0));

    p_ptr_still_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!data_valid && !ptr_load) |=> $stable(ptr));

    // R2: a write strobe only follows a selected byte
    p_we_selected_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |-> $past(hit && data_valid));
endmodule

// File: rtl/readout_drive.sv
module readout_drive (
    input  logic clk,
    input  logic rst_n,
    input  logic hit,
    input  logic rd_req,
    input  logic rd_bit,
    output logic sdo_bit,
    output logic sdo_oe
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sdo_oe  <= 1'b0;
            sdo_bit <= 1'b0;
        end else begin
            sdo_oe  <= rd_req && hit;
            sdo_bit <= rd_req && hit && rd_bit;
        end
    end

    // R6: an unselected slice never drives the shared line
    p_sdo_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |=> !sdo_oe);
endmodule

// File: rtl/clk_role.sv
module clk_role
    import slice_gate_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] strap_q,
    input  logic              osc_ext,
    input  logic              clk_out_en,
    input  logic              disp_en,
    input  logic              osc_clk,
    input  logic              clk_pin_in,
    output logic              clk_out,
    output logic              clk_oe,
    output logic              core_clk
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) clk_oe <= 1'b0;
        else        clk_oe <= (strap_q == MASTER_ADDR) && !osc_ext
                              && clk_out_en && disp_en;
    end

    assign clk_out  = clk_oe & osc_clk;
    assign core_clk = osc_ext ? clk_pin_in : osc_clk;

    // R9: display disable stops the clock output one cycle later
    p_clk_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !disp_en |=> !clk_oe);

    // R8: an externally clocked slice never drives the line
    p_ext_no_drive_r8: assert property (@(posedge clk) disable iff (!rst_n)
        osc_ext |=> !clk_oe);
endmodule

// File: rtl/slice_addr_gate.sv
module slice_addr_gate
    import slice_gate_pkg::*;
#(
    parameter int RAM_DEPTH = 102,
    parameter int DATA_W    = 8,
    localparam int PTR_W    = $clog2(RAM_DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        strap_addr,
    input  logic              bus_active,
    input  logic              addr_load,
    input  logic [1:0]        addr_val,
    input  logic              data_valid,
    input  logic [DATA_W-1:0] data_in,
    input  logic              ptr_load,
    input  logic [PTR_W-1:0]  ptr_val,
    input  logic              rd_req,
    input  logic              rd_bit,
    input  logic              osc_ext,
    input  logic              clk_out_en,
    input  logic              disp_en,
    input  logic              osc_clk,
    input  logic              clk_pin_in,
    output logic              ram_we,
    output logic [PTR_W-1:0]  ram_addr,
    output logic [DATA_W-1:0] ram_wdata,
    output logic [PTR_W-1:0]  ptr,
    output logic              sdo_bit,
    output logic              sdo_oe,
    output logic              clk_out,
    output logic              clk_oe,
    output logic              core_clk
);
    logic [ADDR_W-1:0] strap_q;
    logic              hit;

    addr_select u_sel (
        .clk        (clk),
        .rst_n      (rst_n),
        .strap_addr (strap_addr),
        .bus_active (bus_active),
        .addr_load  (addr_load),
        .addr_val   (addr_val),
        .strap_q    (strap_q),
        .hit        (hit)
    );

    ptr_gate #(.RAM_DEPTH(RAM_DEPTH), .DATA_W(DATA_W)) u_ptr (
        .clk        (clk),
        .rst_n      (rst_n),
        .hit        (hit),
        .data_valid (data_valid),
        .data_in    (data_in),
        .ptr_load   (ptr_load),
        .ptr_val    (ptr_val),
        .ram_we     (ram_we),
        .ram_addr   (ram_addr),
        .ram_wdata  (ram_wdata),
        .ptr        (ptr)
    );

    readout_drive u_rd (
        .clk     (clk),
        .rst_n   (rst_n),
        .hit     (hit),
        .rd_req  (rd_req),
        .rd_bit  (rd_bit),
        .sdo_bit (sdo_bit),
        .sdo_oe  (sdo_oe)
    );

    clk_role u_clk (
        .clk        (clk),
        .rst_n      (rst_n),
        .strap_q    (strap_q),
        .osc_ext    (osc_ext),
        .clk_out_en (clk_out_en),
        .disp_en    (disp_en),
        .osc_clk    (osc_clk),
        .clk_pin_in (clk_pin_in),
        .clk_out    (clk_out),
        .clk_oe     (clk_oe),
        .core_clk   (core_clk)
    );

    // R1: quiet outputs straight after reset
    p_reset_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!ram_we && !sdo_oe && !clk_oe));
endmodule

// File: tb/slice_addr_gate_test.sv
`timescale 1ns/1ps
module slice_addr_gate_test;
    localparam int RAM_DEPTH = 102;
    localparam int DATA_W    = 8;
    localparam int PTR_W     = $clog2(RAM_DEPTH);

    logic clk = 0, rst_n = 0;
    logic [1:0] strap_addr = 0, addr_val = 0;
    logic bus_active = 0, addr_load = 0, data_valid = 0, ptr_load = 0;
    logic [DATA_W-1:0] data_in = 0;
    logic [PTR_W-1:0]  ptr_val = 0;
    logic rd_req = 0, rd_bit = 0, osc_ext = 0, clk_out_en = 0, disp_en = 0;
    logic osc_clk = 0, clk_pin_in = 0;
    logic ram_we, sdo_bit, sdo_oe, clk_out, clk_oe, core_clk;
    logic [PTR_W-1:0]  ram_addr, ptr;
    logic [DATA_W-1:0] ram_wdata;

    int n_chk = 0, n_bad = 0;

    always #4 clk = ~clk;

    slice_addr_gate #(.RAM_DEPTH(RAM_DEPTH), .DATA_W(DATA_W)) uut (.*);

    task automatic check(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step(int n = 1);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic set_addr(logic [1:0] strap, logic [1:0] dev);
        strap_addr = strap; addr_val = dev; addr_load = 1;
        step();
        addr_load = 0;
        step();
    endtask

    task automatic t_reset();
        rst_n = 0;
        #20;
        check("R1 we", ram_we, 0);
        check("R1 ptr", ptr, 0);
        check("R1 sdo_oe", sdo_oe, 0);
        check("R1 clk_oe", clk_oe, 0);
        @(negedge clk); rst_n = 1;
        step();
        // device-address register 00 equals strap 00 -> selected
        data_valid = 1; data_in = 8'h11;
        step();
        data_valid = 0;
        check("R1 devaddr00", ram_we, 1);
        step();
    endtask

    task automatic t_match_write();
        set_addr(2'b10, 2'b10);
        ptr_load = 1; ptr_val = 7'd5;
        step();
        ptr_load = 0;
        data_valid = 1; data_in = 8'hA5;
        step();
        data_valid = 0;
        check("R2 we", ram_we, 1);
        check("R2 addr", ram_addr, 5);
        check("R2 data", ram_wdata, 8'hA5);
        check("R2 ptr", ptr, 6);
        step();
        check("R2 we drop", ram_we, 0);
    endtask

    task automatic t_mismatch();
        set_addr(2'b01, 2'b11);
        ptr_load = 1; ptr_val = 7'd20;
        step();
        ptr_load = 0;
        data_valid = 1; data_in = 8'h3C;
        step();
        check("R3 we", ram_we, 0);
        check("R3 ptr", ptr, 21);
        step();
        data_valid = 0;
        check("R3 ptr2", ptr, 22);
        check("R3 we2", ram_we, 0);
    endtask

    task automatic t_wrap();
        set_addr(2'b00, 2'b00);
        ptr_load = 1; ptr_val = PTR_W'(RAM_DEPTH - 1);
        step();
        ptr_load = 0;
        check("R4 load", ptr, RAM_DEPTH - 1);
        data_valid = 1; data_in = 8'h77;
        step();
        data_valid = 0;
        check("R4 wrap", ptr, 0);
        check("R4 last addr", ram_addr, RAM_DEPTH - 1);
        data_valid = 1; ptr_load = 1; ptr_val = 7'd40;
        step();
        data_valid = 0; ptr_load = 0;
        check("R4 load prio", ptr, 40);
    endtask

    task automatic t_readout();
        set_addr(2'b11, 2'b11);
        rd_req = 1; rd_bit = 1;
        step();
        check("R5 oe", sdo_oe, 1);
        check("R5 bit1", sdo_bit, 1);
        rd_bit = 0;
        step();
        check("R5 bit0", sdo_bit, 0);
        rd_req = 0;
        set_addr(2'b11, 2'b01);
        rd_req = 1; rd_bit = 1;
        step();
        check("R6 oe", sdo_oe, 0);
        check("R6 bit", sdo_bit, 0);
        rd_req = 0;
        step();
    endtask

    task automatic t_strap_hold();
        set_addr(2'b01, 2'b01);
        bus_active = 1;
        step();
        strap_addr = 2'b10;
        step(3);
        data_valid = 1;
        step();
        data_valid = 0;
        check("R7 held", ram_we, 1);
        bus_active = 0;
        step();
        step();
        data_valid = 1;
        step();
        data_valid = 0;
        check("R7 resampled", ram_we, 0);
    endtask

    task automatic t_clock_role();
        set_addr(2'b00, 2'b00);
        osc_ext = 0; clk_out_en = 1; disp_en = 1; osc_clk = 1;
        step();
        check("R8 master", clk_oe, 1);
        #1;
        check("R9 out hi", clk_out, 1);
        osc_clk = 0; #1;
        check("R9 out lo", clk_out, 0);
        osc_clk = 1;
        disp_en = 0;
        step();
        check("R9 disp off", clk_oe, 0);
        #1;
        check("R9 out gated", clk_out, 0);
        disp_en = 1; clk_out_en = 0;
        step();
        check("R8 coe off", clk_oe, 0);
        clk_out_en = 1; osc_ext = 1;
        step();
        check("R8 ext", clk_oe, 0);
        osc_ext = 0;
        set_addr(2'b10, 2'b10);
        check("R8 nonmaster", clk_oe, 0);
        disp_en = 0; clk_out_en = 0;
        step();
    endtask

    task automatic t_clk_src();
        osc_ext = 1; clk_pin_in = 1; osc_clk = 0; #1;
        check("R10 ext", core_clk, 1);
        clk_pin_in = 0; osc_clk = 1; #1;
        check("R10 ext lo", core_clk, 0);
        osc_ext = 0; #1;
        check("R10 int", core_clk, 1);
        osc_clk = 0; #1;
        check("R10 int lo", core_clk, 0);
    endtask

    initial begin
        t_reset();
        t_match_write();
        t_mismatch();
        t_wrap();
        t_readout();
        t_strap_hold();
        t_clock_role();
        t_clk_src();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #100000;
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=0 expected=1");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule